// File: doc/BRIEF.md
# Protected Load Switch Sequencer

This block is the digital sequencer behind a power-path switch that sits between a connector supply rail and the system rail. It decides when the pass transistor may conduct, and how its gate is brought up. An active-low enable requests conduction. Three fault sources can override that request: an overvoltage flag, an undervoltage-lockout flag and a digitized die-temperature code. All three reach the block already synchronized to its clock. The analog comparators, the charge pump and the transistor itself sit outside.

A valid start does not turn the switch on at once. The sequencer first waits a turn-on delay. It then raises a multi-bit gate-drive level one step at a time, which limits inrush current, and it reports the switch fully on by pulling an open-drain acknowledge line low. Any fault or a disable removes the gate drive in the same cycle, without waiting for a clock edge. Once an overvoltage clears, the sequencer waits its own recovery interval and then ramps again; it does not repeat the turn-on delay. The durations are parameters in clock cycles: at 100 MHz the defaults give a 20 ms delay, a 20 ms recovery and a ramp of about 4 ms. A short status code names the fault that currently holds the switch off.

Top module: `load_switch_seq`

## Requirements
- R1: While reset is asserted, and right after it, the block is off: `gate_lvl` is 0, `sw_on` is 0 and `ack_pd` is 0 (line released). This holds even when `en_n` is low.
- R2: While `en_n` is high, `gate_lvl`, `sw_on` and `ack_pd` are 0 in that same cycle, and no turn-on sequence advances.
- R3: The first clock edge that sees `en_n` low with no fault enters the delay phase. The delay phase lasts `DLY_CYC` cycles with `gate_lvl` at 0, and the ramp phase follows.
- R4: In the ramp phase `gate_lvl` starts at 0 and rises by exactly 1 every `STEP_CYC` cycles up to the full-scale code 2^`GATE_W`-1. The edge after full scale is reached enters the fully-on state, which holds full scale.
- R5: `ack_pd` is 1 only in the fully-on state while no fault is active and `en_n` is low. `sw_on` is 1 in the ramp and fully-on states under the same conditions.
- R6: In a cycle where `ovp_flag` is 1, `gate_lvl`, `sw_on` and `ack_pd` are 0 in that same cycle, whatever the state.
- R7: After `ovp_flag` falls, with no other fault and `en_n` low, the block waits `REC_CYC` cycles with the gate at 0. It then ramps as in R4, with no turn-on delay. The recovery count restarts from zero if the overvoltage returns.
- R8: The switch is held off once `temp_code` >= `TRIP_CODE`. It stays off until `temp_code` falls below `TRIP_CODE - HYST_CODE`, and after that release it restarts with the full turn-on delay.
- R9: While `uvlo_flag` is 1 the switch is off and `ack_pd` is 0. After the flag clears, the block restarts with the full turn-on delay.
- R10: A disable or any fault during the delay or ramp phase aborts that phase. The next valid start runs the full delay again from zero.
- R11: `fault_code` shows the highest-priority active fault in the same cycle: 1 for thermal, 2 for overvoltage, 3 for undervoltage lockout, 0 for none. Thermal outranks overvoltage, which outranks undervoltage. Thermal also outranks overvoltage in choosing between the off and recovery paths.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_n | input | 1 | Active-low switch enable |
| ovp_flag | input | 1 | Connector overvoltage flag, synchronized |
| uvlo_flag | input | 1 | Connector undervoltage-lockout flag, synchronized |
| temp_code | input | TEMP_W | Die-temperature code, one LSB per degree C |
| gate_lvl | output | GATE_W | Soft-start gate-drive level |
| sw_on | output | 1 | Switch is ramping or fully on |
| ack_pd | output | 1 | Pull-down enable for the open-drain acknowledge line |
| fault_code | output | 2 | Active fault: 0 none, 1 thermal, 2 overvoltage, 3 undervoltage |

## Verification
The bench targets the edges of each interval. It checks the last delay cycle against the first ramp step, the last recovery cycle, and the cycle in which full scale hands over to fully on. A counter that is off by one moves every one of these transitions by one cycle, and the bench reports the mismatch. The bench applies an overvoltage in the fully-on state. A design that waits for a clock edge before cutting the gate would keep full drive and the acknowledge for one cycle. Recovery must skip the delay, so a design that reruns the turn-on delay instead lands many cycles late. A temperature between the release and trip codes must keep the switch off after a trip. A design without hysteresis would restart there. An undervoltage pulse in mid-ramp must force a full new delay, which exposes a design that resumes the ramp. Simultaneous faults check the status priority.

// File: rtl/lss_pkg.sv
package lss_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_DELAY = 3'd1,
    ST_RAMP  = 3'd2,
    ST_ON    = 3'd3,
    ST_RECOV = 3'd4
  } lss_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_THERM = 2'd1,
    FLT_OVP   = 2'd2,
    FLT_UVLO  = 2'd3
  } lss_fault_e;

  // Highest gate code for a ramp of the given width.
  function automatic int unsigned full_scale(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

  // Temperature code below which a tripped thermal guard lets go.
  function automatic int unsigned release_code(input int unsigned trip,
                                               input int unsigned hyst);
    return (trip > hyst) ? (trip - hyst) : 32'd0;
  endfunction

  // Counter width that can hold values 0..max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/lss_thermal.sv
module lss_thermal #(
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned TRIP_CODE = 145,
  parameter int unsigned HYST_CODE = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              hot
);
  import lss_pkg::*;

  localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(TRIP_CODE);
  localparam logic [TEMP_W-1:0] REL_C  = TEMP_W'(release_code(TRIP_CODE, HYST_CODE));

  logic hot_q;

  // Once tripped, stay hot down to the release code.
  assign hot = hot_q ? (temp_code >= REL_C) : (temp_code >= TRIP_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hot_q <= 1'b0;
    else        hot_q <= hot;
  end
endmodule

// File: rtl/lss_fault_arb.sv
module lss_fault_arb (
  input  logic               therm_hot,
  input  logic               ovp,
  input  logic               uvlo,
  input  logic               en_n,
  output logic               blocked,
  output lss_pkg::lss_fault_e cause
);
  import lss_pkg::*;

  always_comb begin
    if (therm_hot)  cause = FLT_THERM;
    else if (ovp)   cause = FLT_OVP;
    else if (uvlo)  cause = FLT_UVLO;
    else            cause = FLT_NONE;
  end

  assign blocked = therm_hot | ovp | uvlo | en_n;
endmodule

// File: rtl/lss_ramp.sv
module lss_ramp #(
  parameter int unsigned GATE_W   = 8,
  parameter int unsigned STEP_CYC = 1568
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  output logic [GATE_W-1:0] lvl,
  output logic              at_full
);
  import lss_pkg::*;

  localparam int unsigned PRE_W = cnt_width(STEP_CYC - 1);
  localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(STEP_CYC - 1);
  localparam logic [GATE_W-1:0] FULL_LVL = GATE_W'(full_scale(GATE_W));

  logic [PRE_W-1:0] pre_q;
  logic             step_tick;

  assign step_tick = run && (pre_q == PRE_LAST);
  assign at_full   = (lvl == FULL_LVL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      lvl   <= '0;
    end else if (clr) begin
      pre_q <= '0;
      lvl   <= '0;
    end else if (run) begin
      pre_q <= step_tick ? '0 : pre_q + 1'b1;
      if (step_tick && !at_full) lvl <= lvl + 1'b1;
    end
  end
endmodule

// File: rtl/load_switch_seq.sv
module load_switch_seq #(
  parameter int unsigned DLY_CYC   = 2000000,
  parameter int unsigned REC_CYC   = 2000000,
  parameter int unsigned STEP_CYC  = 1568,
  parameter int unsigned GATE_W    = 8,
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned TRIP_CODE = 145,
  parameter int unsigned HYST_CODE = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              ovp_flag,
  input  logic              uvlo_flag,
  input  logic [TEMP_W-1:0] temp_code,
  output logic [GATE_W-1:0] gate_lvl,
  output logic              sw_on,
  output logic              ack_pd,
  output logic [1:0]        fault_code
);
  import lss_pkg::*;

  localparam int unsigned CNT_MAX = (DLY_CYC > REC_CYC) ? DLY_CYC : REC_CYC;
  localparam int unsigned CNT_W   = cnt_width(CNT_MAX);
  localparam logic [CNT_W-1:0]  DLY_LAST = CNT_W'(DLY_CYC - 1);
  localparam logic [CNT_W-1:0]  REC_LAST = CNT_W'(REC_CYC - 1);
  localparam logic [GATE_W-1:0] FULL_LVL = GATE_W'(full_scale(GATE_W));

  lss_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Named internal events, also visible to the bound checker.
  logic             therm_hot;
  logic             blocked;
  logic             phase_done;
  logic             ramp_full;
  logic [GATE_W-1:0] ramp_lvl;
  lss_fault_e       cause;

  lss_thermal #(
    .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE), .HYST_CODE(HYST_CODE)
  ) u_thermal (
    .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .hot(therm_hot)
  );

  lss_fault_arb u_arb (
    .therm_hot(therm_hot), .ovp(ovp_flag), .uvlo(uvlo_flag), .en_n(en_n),
    .blocked(blocked), .cause(cause)
  );

  lss_ramp #(
    .GATE_W(GATE_W), .STEP_CYC(STEP_CYC)
  ) u_ramp (
    .clk(clk), .rst_n(rst_n),
    .clr(state_q != ST_RAMP),
    .run((state_q == ST_RAMP) && !blocked),
    .lvl(ramp_lvl), .at_full(ramp_full)
  );

  assign phase_done = ((state_q == ST_DELAY) && (cnt_q == DLY_LAST)) ||
                      ((state_q == ST_RECOV) && (cnt_q == REC_LAST));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (therm_hot) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else if (ovp_flag) begin
      state_d = ST_RECOV;
      cnt_d   = '0;
    end else if (blocked) begin
      state_d = ST_OFF;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_DELAY;
          cnt_d   = '0;
        end
        ST_DELAY, ST_RECOV: begin
          if (phase_done) begin
            state_d = ST_RAMP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RAMP: if (ramp_full) state_d = ST_ON;
        ST_ON:   state_d = ST_ON;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Output cut-off is combinational on the fault inputs.
  always_comb begin
    if (blocked)                gate_lvl = '0;
    else if (state_q == ST_ON)  gate_lvl = FULL_LVL;
    else if (state_q == ST_RAMP) gate_lvl = ramp_lvl;
    else                        gate_lvl = '0;
  end

  assign sw_on      = !blocked && ((state_q == ST_RAMP) || (state_q == ST_ON));
  assign ack_pd     = !blocked && (state_q == ST_ON);
  assign fault_code = cause;
endmodule

// File: rtl/lss_checker.sv
module lss_checker #(
  parameter int unsigned GATE_W    = 8,
  parameter int unsigned TEMP_W    = 8,
  parameter int unsigned TRIP_CODE = 145
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_n,
  input logic              ovp_flag,
  input logic              uvlo_flag,
  input logic [TEMP_W-1:0] temp_code,
  input logic [GATE_W-1:0] gate_lvl,
  input logic              sw_on,
  input logic              ack_pd,
  input logic [1:0]        fault_code,
  input logic              phase_done,
  input logic              ramp_full
);
  localparam logic [GATE_W-1:0] FULL_LVL = {GATE_W{1'b1}};
  localparam logic [TEMP_W-1:0] TRIP_C   = TEMP_W'(TRIP_CODE);

  AST_EN_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> (gate_lvl == '0) && !sw_on && !ack_pd); // R2

  AST_RAMP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_on) |-> (gate_lvl == '0)); // R4

  AST_RAMP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_on && $past(sw_on)) |->
      ((gate_lvl == $past(gate_lvl)) || (gate_lvl == $past(gate_lvl) + 1'b1))); // R4

  AST_ACK_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pd |-> (sw_on && (gate_lvl == FULL_LVL))); // R5

  AST_ACK_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_pd) |-> $past(ramp_full) || $past(ovp_flag) || $past(uvlo_flag) || $past(en_n)); // R4

  AST_OVP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_flag |-> (gate_lvl == '0) && !sw_on && !ack_pd); // R6

  AST_RAMP_AFTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !en_n && !ovp_flag && !uvlo_flag && (temp_code < TRIP_C) && (fault_code == 2'd0))
      |=> (gate_lvl == '0)); // R3

  AST_THERM_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_code >= TRIP_C) |-> !sw_on && (fault_code == 2'd1)); // R8

  AST_UVLO_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |-> !sw_on && !ack_pd); // R9

  AST_STATUS_OVP: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd2) |-> ovp_flag); // R11

  AST_STATUS_UVLO: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == 2'd3) |-> uvlo_flag && !ovp_flag); // R11
endmodule

bind load_switch_seq lss_checker #(
  .GATE_W(GATE_W), .TEMP_W(TEMP_W), .TRIP_CODE(TRIP_CODE)
) u_lss_checker (
  .clk(clk), .rst_n(rst_n), .en_n(en_n), .ovp_flag(ovp_flag),
  .uvlo_flag(uvlo_flag), .temp_code(temp_code), .gate_lvl(gate_lvl),
  .sw_on(sw_on), .ack_pd(ack_pd), .fault_code(fault_code),
  .phase_done(phase_done), .ramp_full(ramp_full)
);

// File: tb/tb_load_switch_seq.sv
module tb_load_switch_seq;
  localparam int DLY  = 20;
  localparam int REC  = 12;
  localparam int STEP = 2;
  localparam int GW   = 3;
  localparam int TOP  = 7;     // 2**GW - 1
  localparam int TRIP = 145;
  localparam int REL  = 110;   // TRIP - 35

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_n = 1'b0;
  logic          ovp_flag = 1'b0;
  logic          uvlo_flag = 1'b0;
  logic [7:0]    temp_code = 8'd25;
  logic [GW-1:0] gate_lvl;
  logic          sw_on;
  logic          ack_pd;
  logic [1:0]    fault_code;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference model: 0 off, 1 delay, 2 ramp, 3 on, 4 recovery
  int m_st = 0, m_cnt = 0, m_pre = 0, m_lvl = 0;
  bit m_hot = 1'b0;

  always #5 clk = ~clk;

  load_switch_seq #(
    .DLY_CYC(DLY), .REC_CYC(REC), .STEP_CYC(STEP), .GATE_W(GW),
    .TEMP_W(8), .TRIP_CODE(TRIP), .HYST_CODE(35)
  ) dut (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .ovp_flag(ovp_flag),
    .uvlo_flag(uvlo_flag), .temp_code(temp_code), .gate_lvl(gate_lvl),
    .sw_on(sw_on), .ack_pd(ack_pd), .fault_code(fault_code)
  );

  function automatic bit hot_now();
    return m_hot ? (int'(temp_code) >= REL) : (int'(temp_code) >= TRIP);
  endfunction

  task automatic compare(input string req);
    bit blk;
    int e_gate, e_fc;
    bit e_sw, e_ack;
    blk    = hot_now() || ovp_flag || uvlo_flag || en_n;
    e_gate = blk ? 0 : (m_st == 2 ? m_lvl : (m_st == 3 ? TOP : 0));
    e_sw   = !blk && (m_st == 2 || m_st == 3);
    e_ack  = !blk && (m_st == 3);
    e_fc   = hot_now() ? 1 : (ovp_flag ? 2 : (uvlo_flag ? 3 : 0));
    n_vec++;
    if (int'(gate_lvl) != e_gate || sw_on != e_sw || ack_pd != e_ack ||
        int'(fault_code) != e_fc) begin
      n_bad++;
      $display("FAIL %s t=%0t gate/sw/ack/fc actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               req, $time, gate_lvl, sw_on, ack_pd, fault_code, e_gate, e_sw, e_ack, e_fc);
    end
  endtask

  task automatic model_clock();
    bit h;
    h = hot_now();
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_pre = 0; m_lvl = 0; m_hot = 0;
      return;
    end
    m_hot = h;
    if (h)                       begin m_st = 0; m_cnt = 0; m_lvl = 0; m_pre = 0; end
    else if (ovp_flag)           begin m_st = 4; m_cnt = 0; m_lvl = 0; m_pre = 0; end
    else if (uvlo_flag || en_n)  begin m_st = 0; m_cnt = 0; m_lvl = 0; m_pre = 0; end
    else begin
      case (m_st)
        0: begin m_st = 1; m_cnt = 0; end
        1, 4: begin
          if (m_cnt == ((m_st == 1) ? DLY : REC) - 1) begin
            m_st = 2; m_cnt = 0; m_lvl = 0; m_pre = 0;
          end else m_cnt++;
        end
        2: begin
          if (m_lvl == TOP) m_st = 3;
          else if (m_pre == STEP - 1) begin m_pre = 0; m_lvl++; end
          else m_pre++;
        end
        default: m_st = 3;
      endcase
    end
  endtask

  task automatic run(input int n, input bit en, input bit ov, input bit uv,
                     input int temp, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en_n = en; ovp_flag = ov; uvlo_flag = uv; temp_code = 8'(temp);
      #1 compare(req);
      @(posedge clk);
      model_clock();
    end
  endtask

  initial begin
    // R1: reset with enable asserted
    run(3, 1'b0, 1'b0, 1'b0, 25, "R1");
    @(negedge clk); rst_n = 1'b1;
    #1 compare("R1");
    @(posedge clk); model_clock();
    run(2, 1'b0, 1'b0, 1'b0, 25, "R1");
    // R2: disable holds off
    run(6, 1'b1, 1'b0, 1'b0, 25, "R2");
    // R3, R4, R5: delay, ramp, fully on
    run(DLY + TOP * STEP + 8, 1'b0, 1'b0, 1'b0, 25, "R3 R4 R5");
    // R2: disable from fully on cuts at once
    run(1, 1'b1, 1'b0, 1'b0, 25, "R2");
    run(DLY + TOP * STEP + 4, 1'b0, 1'b0, 1'b0, 25, "R3 R5");
    // R6, R7: overvoltage, then recovery without delay
    run(3, 1'b0, 1'b1, 1'b0, 25, "R6");
    run(5, 1'b0, 1'b0, 1'b0, 25, "R7");
    run(1, 1'b0, 1'b1, 1'b0, 25, "R6 R7");
    run(REC + TOP * STEP + 6, 1'b0, 1'b0, 1'b0, 25, "R7");
    // R8: thermal trip and hysteresis
    run(3, 1'b0, 1'b0, 1'b0, 145, "R8");
    run(6, 1'b0, 1'b0, 1'b0, 120, "R8");
    run(3, 1'b0, 1'b0, 1'b0, 110, "R8");
    run(DLY + TOP * STEP + 4, 1'b0, 1'b0, 1'b0, 109, "R8");
    run(2, 1'b0, 1'b0, 1'b0, 144, "R8");
    // R9: undervoltage lockout
    run(4, 1'b0, 1'b0, 1'b1, 25, "R9");
    run(DLY + TOP * STEP + 4, 1'b0, 1'b0, 1'b0, 25, "R9");
    // R10: abort in delay, then in ramp
    run(1, 1'b1, 1'b0, 1'b0, 25, "R10");
    run(DLY - 5, 1'b0, 1'b0, 1'b0, 25, "R10");
    run(2, 1'b1, 1'b0, 1'b0, 25, "R10");
    run(DLY + 7, 1'b0, 1'b0, 1'b0, 25, "R10");
    run(1, 1'b0, 1'b0, 1'b1, 25, "R10");
    run(DLY + TOP * STEP + 4, 1'b0, 1'b0, 1'b0, 25, "R10");
    // R11: simultaneous faults and priority
    run(2, 1'b0, 1'b1, 1'b1, 150, "R11");
    run(2, 1'b0, 1'b1, 1'b1, 100, "R11");
    run(2, 1'b0, 1'b0, 1'b1, 100, "R11");
    run(2, 1'b1, 1'b0, 1'b0, 100, "R11");
    run(3, 1'b0, 1'b1, 1'b0, 150, "R11");
    run(REC + DLY + TOP * STEP + 4, 1'b0, 1'b0, 1'b0, 25, "R11");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule